// File: doc/BRIEF.md
# Banked Crossbar Switch with Staged Routing Configuration

This block is a switching core made of eight independent 8x8 crossbars. Each crossbar takes eight single-bit inputs and drives eight single-bit outputs. Each output picks one of the eight inputs of its own group through a 3-bit source select. Data moves from input to output through combinational logic only.

All selects together form a 192-bit routing image, which is held at two levels. The staging copy is loaded from outside over a 12-bit word port. Each write strobe carries a 4-bit word address, and sixteen words fill the image. The active copy drives the crossbar selects. A commit strobe copies the whole staging image into the active copy on one clock edge. Because of this, the routing never shows a half-loaded configuration.

A completion flag rises once every word address has been written at least once since the last commit. Software can watch this flag to know when a commit is safe.

Top module: `xbar_bank`

## Requirements
- R1: During and after reset, both the staging and active images hold the identity map, so output j of every group copies input j. The completion flag is 0.
- R2: Output bit `dout[k*8+j]` equals `din[k*8+s]`, where s is the 3-bit field at bits `[(k*8+j)*3 +: 3]` of the active image. The output follows `din` in the same cycle, with no register.
- R3: A write with `cfg_we`=1 stores `cfg_word` into bits `[cfg_addr*12 +: 12]` of the staging image. Without a commit, writes leave the outputs unchanged.
- R4: When `commit` is 1 at a rising edge, the active image takes the staging image as it stood before that edge. The new routing is seen from that edge on.
- R5: A write in the same cycle as a commit is not part of that commit. It reaches the outputs only at the next commit.
- R6: `load_done` is 1 exactly when each of the 16 word addresses has been written at least once since the last commit or reset. Writing the same address again does not count as a new address.
- R7: A commit clears the record of written addresses. A write in the same cycle as the commit counts toward the next load.
- R8: A commit does not clear the staging image. Words that are not rewritten keep their values, and a later commit applies them again.
- R9: Each group is independent. Inputs of group k never affect the outputs of any other group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 64 | Data inputs, group k at bits [k*8 +: 8] |
| dout | output | 64 | Data outputs, group k at bits [k*8 +: 8] |
| cfg_we | input | 1 | Staging word write strobe |
| cfg_addr | input | 4 | Staging word address |
| cfg_word | input | 12 | Staging word data |
| commit | input | 1 | Copy staging image to active image |
| load_done | output | 1 | All words written since last commit |

## Verification
A corrupted select field in the active image shows at once on `dout`. One output of one group then copies the wrong input, and this is visible in the same cycle that `din` tells the two inputs apart. A fault in the staging image or in the commit path stays hidden until the next commit, and appears on the cycle after that commit edge. For this reason the bench commits often and drives random data on every cycle. A wrong address record shows on `load_done` when the sixteenth distinct write lands, or just after a commit.

// File: rtl/xbar_bank.sv
module xbar_bank #(
  parameter int GROUPS = 8,
  parameter int PORTS  = 8,
  parameter int WORD_W = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GROUPS*PORTS-1:0]   din,
  output logic [GROUPS*PORTS-1:0]   dout,
  input  logic                      cfg_we,
  input  logic [3:0]                cfg_addr,
  input  logic [WORD_W-1:0]         cfg_word,
  input  logic                      commit,
  output logic                      load_done
);
  localparam int SEL_W = $clog2(PORTS);
  localparam int LANES = GROUPS * PORTS;
  localparam int CFG_W = LANES * SEL_W;
  localparam int WORDS = CFG_W / WORD_W;

  function automatic logic [CFG_W-1:0] ident_map();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int k = 0; k < GROUPS; k++)
      for (int j = 0; j < PORTS; j++)
        m[(k*PORTS+j)*SEL_W +: SEL_W] = SEL_W'(j);
    return m;
  endfunction

  localparam logic [CFG_W-1:0] IDENT = ident_map();

  logic [CFG_W-1:0] shadow, live;
  logic [WORDS-1:0] seen;
  logic             wr_ok;

  assign wr_ok     = cfg_we && (int'(cfg_addr) < WORDS);
  assign load_done = &seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= IDENT;
      live   <= IDENT;
      seen   <= '0;
    end else begin
      if (commit) begin
        live <= shadow;
        seen <= '0;
      end
      if (wr_ok) begin
        shadow[int'(cfg_addr)*WORD_W +: WORD_W] <= cfg_word;
        seen[cfg_addr] <= 1'b1;
      end
    end
  end

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    logic [PORTS-1:0] gin;
    assign gin = din[k*PORTS +: PORTS];
    for (genvar j = 0; j < PORTS; j++) begin : g_out
      logic [SEL_W-1:0] sel;
      assign sel = live[(k*PORTS+j)*SEL_W +: SEL_W];
      assign dout[k*PORTS+j] = gin[sel];
    end
  end

  assert_live_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live));
  assert_commit_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> live == $past(shadow));
  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !cfg_we) |=> !load_done);
  assert_done_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_done) |-> $past(cfg_we));
  assert_shadow_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(shadow));
endmodule

// File: tb/xbar_bank_test.sv
module xbar_bank_test;
  logic clk = 0, rst_n = 0;
  logic [63:0] din = '0;
  logic [63:0] dout;
  logic cfg_we = 0, commit = 0, load_done;
  logic [3:0] cfg_addr = '0;
  logic [11:0] cfg_word = '0;
  int checks = 0, errors = 0;
  logic [191:0] m_sh, m_live;
  logic [15:0] m_seen;

  xbar_bank uut (.clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_word(cfg_word), .commit(commit), .load_done(load_done));

  always #10 clk = ~clk;

  function automatic logic [191:0] ident();
    logic [191:0] m;
    for (int i = 0; i < 64; i++) m[i*3 +: 3] = 3'(i % 8);
    return m;
  endfunction

  function automatic logic [63:0] route(logic [191:0] cfg, logic [63:0] d);
    logic [63:0] o;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++)
        o[k*8+j] = d[k*8 + int'(cfg[(k*8+j)*3 +: 3])];
    return o;
  endfunction

  task automatic chk_out(string tag);
    checks++;
    if (dout !== route(m_live, din)) begin
      errors++;
      $display("FAIL %s dout=%h expected=%h", tag, dout, route(m_live, din));
    end
  endtask

  task automatic chk_done(string tag);
    checks++;
    if (load_done !== (&m_seen)) begin
      errors++;
      $display("FAIL %s load_done=%b expected=%b", tag, load_done, &m_seen);
    end
  endtask

  task automatic cyc(bit we, logic [3:0] a, logic [11:0] w, bit c, logic [63:0] d, string tag);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_word = w; commit = c; din = d;
    #2;
    chk_out(tag);
    @(posedge clk);
    if (c) begin m_live = m_sh; m_seen = '0; end
    if (we) begin m_sh[int'(a)*12 +: 12] = w; m_seen[a] = 1'b1; end
  endtask

  initial begin
    #(20*200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [191:0] rev;
    void'($urandom(1234));
    m_sh = ident(); m_live = ident(); m_seen = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); din = 64'h0123_4567_89AB_CDEF; #2;
    chk_out("R1 identity in reset"); chk_done("R1 done low");
    rst_n = 1;
    // R1 identity after reset, several patterns
    cyc(0, 0, 0, 0, 64'hFFFF_0000_AAAA_5555, "R1 identity");
    cyc(0, 0, 0, 0, {$urandom, $urandom}, "R1 identity rand");
    // reverse map: output j takes input 7-j
    for (int i = 0; i < 64; i++) rev[i*3 +: 3] = 3'(7 - i % 8);
    for (int a = 0; a < 16; a++) begin
      cyc(1, 4'(a), rev[a*12 +: 12], 0, {$urandom, $urandom}, "R3 no effect while loading");
      if (a == 14) chk_done("R6 not yet done at 15 words");
    end
    @(negedge clk); chk_done("R6 done after 16 words");
    cyc(0, 0, 0, 1, 64'h8000_0000_0000_0001, "R4 commit cycle old map");
    cyc(0, 0, 0, 0, 64'h8000_0000_0000_0001, "R4 reversed map");
    @(negedge clk); chk_done("R7 cleared after commit");
    // R5 write with commit
    cyc(1, 4'd0, 12'hFFF, 1, {$urandom, $urandom}, "R5 write+commit");
    cyc(0, 0, 0, 0, {$urandom, $urandom}, "R5 write not in live");
    @(negedge clk); chk_done("R7 concurrent write counted");
    cyc(0, 0, 0, 1, {$urandom, $urandom}, "R5 second commit");
    cyc(0, 0, 0, 0, {$urandom, $urandom}, "R5 write now live / R8 kept words");
    // R6 repeated address
    for (int a = 0; a < 16; a++) cyc(1, 4'd3, 12'(a * 37), 0, {$urandom, $urandom}, "R3 repeat addr");
    @(negedge clk); chk_done("R6 repeats not counted");
    cyc(0, 0, 0, 1, {$urandom, $urandom}, "R8 partial commit");
    // R9 group independence: toggle only group 3
    for (int t = 0; t < 8; t++) cyc(0, 0, 0, 0, 64'(8'(1 << t)) << 24, "R9 group isolation");
    cyc(0, 0, 0, 0, 64'hFF << 24, "R9 group isolation all");
    // random
    for (int n = 0; n < 600; n++) begin
      cyc(($urandom % 3) != 0, 4'($urandom), 12'($urandom), ($urandom % 23) == 0,
          {$urandom, $urandom}, "R2 random routing");
      chk_done("R6 random done");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule